// File: doc/BRIEF.md
# Divided-Edge Phase Frequency Detector Core

This block is the clocked digital heart of an integer-N frequency synthesizer. All of its logic runs on one fast system clock. Two single-cycle input strobes mark edges of a reference source and of a feedback source. A 14-bit reference divider turns every R reference strobes into one divided pulse. A 13-bit feedback divider does the same for every N feedback strobes. The two divided pulses feed a tri-state phase frequency detector. The detector raises `up` when the reference pulse comes first and `down` when the feedback pulse comes first.

Once both detector outputs are high, they stay high together for a selectable number of system-clock cycles and then clear in the same cycle. This fixed overlap is the anti-backlash window. It keeps the detector free of a dead zone near phase lock. A warning output flags the shortest window, which is supported but not advised. A power-down input holds the dividers and the detector cleared and blocks both strobes.

Top module: `pfd_divcore`

## Requirements
- R1: With `refRatio` = R in 1..16383, `refPulse` is high for exactly one cycle, in the cycle after every R-th accepted `refStrobe`, and is low at all other times.
- R2: With `fbRatio` = N in 1..8191, `fbPulse` is high for exactly one cycle, in the cycle after every N-th accepted `fbStrobe`, and is low at all other times.
- R3: A ratio value of 0 behaves exactly like a ratio of 1, so every accepted strobe produces a pulse.
- R4: A divider reads its ratio input when a count starts, that is, on the first strobe after a terminal count or after a clear. A ratio change made partway through a count takes effect only after that count reaches its terminal value.
- R5: `up` rises in the cycle after a `refPulse`, and `down` rises in the cycle after an `fbPulse`. The output that rose first stays high alone until the other one rises.
- R6: Once `up` and `down` are both high, both stay high for exactly D cycles and then fall in the same cycle. D depends on `abpSel`: code 2'b01 gives 2 cycles, 2'b00 gives 4, 2'b10 gives 6 and 2'b11 gives 8. The same holds when both outputs rise in the same cycle.
- R7: `abpShortWarn` is high exactly when `abpSel` equals 2'b01. This holds in power-down as well.
- R8: While `powerDown` is high, `up`, `down`, `refPulse` and `fbPulse` are low from the next cycle on, and strobes are not counted. After release, each divider counts a full ratio from zero.
- R9: After `rstN` is deasserted, `up`, `down`, `refPulse` and `fbPulse` are low and both dividers start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refStrobe | input | 1 | One-cycle marker of a reference edge |
| fbStrobe | input | 1 | One-cycle marker of a feedback edge |
| refRatio | input | 14 | Reference divide ratio (0 treated as 1) |
| fbRatio | input | 13 | Feedback divide ratio (0 treated as 1) |
| abpSel | input | 2 | Anti-backlash window select |
| powerDown | input | 1 | Holds dividers and detector cleared |
| up | output | 1 | Detector output: reference leads |
| down | output | 1 | Detector output: feedback leads |
| refPulse | output | 1 | Divided reference pulse |
| fbPulse | output | 1 | Divided feedback pulse |
| abpShortWarn | output | 1 | Shortest window selected |

## Verification
The overlap-length assertion assumes that `abpSel` does not change while `up` and `down` are both high. If the window were shortened partway through an overlap, the delay counter could already be past the new limit. The directed scenarios therefore set `abpSel` only while the detector is idle, just after a reset. Strobes are driven as isolated single-cycle pulses, and the ratios are changed only between strobes. This matches the sampled edge inputs the dividers expect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int DLY_W = 4;
  localparam logic [1:0] ABP_SHORT_CODE = 2'b01;

  typedef struct packed {
    logic holdAll;
    logic clrDet;
  } pfd_ctrl_t;

  // Window length in system-clock cycles for each select code.
  function automatic logic [DLY_W-1:0] abpCycles(input logic [1:0] code);
    logic [DLY_W-1:0] n;
    case (code)
      2'b01:   n = DLY_W'(2);
      2'b00:   n = DLY_W'(4);
      2'b10:   n = DLY_W'(6);
      default: n = DLY_W'(8);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pfd_divider.sv
module pfd_divider #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic         strobe,
  input  logic [W-1:0] ratio,
  output logic         pulse
);

  logic [W-1:0] cnt;
  logic [W-1:0] activeRatio;
  logic [W-1:0] effRatio;
  logic [W-1:0] limit;
  logic         atTerm;
  logic         take;

  assign effRatio = (ratio == '0) ? W'(1) : ratio;
  // A fresh count reads the live ratio; a running count uses the latched one.
  assign limit    = (cnt == '0) ? effRatio : activeRatio;
  assign atTerm   = (cnt == limit - W'(1));
  assign take     = strobe && !hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      activeRatio <= W'(1);
      pulse       <= 1'b0;
    end else if (hold) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= take && atTerm;
      if (take) begin
        if (cnt == '0) activeRatio <= effRatio;
        if (atTerm) cnt <= '0;
        else        cnt <= cnt + W'(1);
      end
    end
  end

  p_pulse_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> $past(strobe));

  p_ratio_frozen_mid_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) && !hold |=> $stable(activeRatio));

  p_hold_quiets_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> !pulse && (cnt == '0));

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int REF_W = 14,
  parameter int FB_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  pfd_ctrl_t        ctrl,
  input  logic             refStrobe,
  input  logic             fbStrobe,
  input  logic [REF_W-1:0] refRatio,
  input  logic [FB_W-1:0]  fbRatio,
  output logic             upQ,
  output logic             dnQ,
  output logic             refPulse,
  output logic             fbPulse
);

  pfd_divider #(.W(REF_W)) u_refDiv (
    .clk    (clk),
    .rstN   (rstN),
    .hold   (ctrl.holdAll),
    .strobe (refStrobe),
    .ratio  (refRatio),
    .pulse  (refPulse)
  );

  pfd_divider #(.W(FB_W)) u_fbDiv (
    .clk    (clk),
    .rstN   (rstN),
    .hold   (ctrl.holdAll),
    .strobe (fbStrobe),
    .ratio  (fbRatio),
    .pulse  (fbPulse)
  );

  // Detector state: each output is set by its own divided edge and cleared by the shared clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (ctrl.holdAll || ctrl.clrDet) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      if (refPulse) upQ <= 1'b1;
      if (fbPulse)  dnQ <= 1'b1;
    end
  end

  p_up_rises_on_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upQ) |-> $past(refPulse));

  p_dn_rises_on_fb_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnQ) |-> $past(fbPulse));

  p_fall_together_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(upQ) |-> !dnQ);

  p_hold_clears_det_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdAll |=> !upQ && !dnQ);

endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDown,
  input  logic [1:0] abpSel,
  input  logic       upQ,
  input  logic       dnQ,
  output pfd_ctrl_t  ctrl,
  output logic       shortWarn
);

  logic [DLY_W-1:0] dcnt;
  logic [DLY_W-1:0] dlyCycles;
  logic             bothHigh;
  logic             clrNow;

  assign dlyCycles = abpCycles(abpSel);
  assign bothHigh  = upQ && dnQ;
  assign clrNow    = bothHigh && (dcnt >= dlyCycles - DLY_W'(1));
  assign shortWarn = (abpSel == ABP_SHORT_CODE);

  always_comb begin
    ctrl         = '0;
    ctrl.holdAll = powerDown;
    ctrl.clrDet  = clrNow;
  end

  // Counts the cycles in which both detector outputs have been high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            dcnt <= '0;
    else if (powerDown || !bothHigh || clrNow) dcnt <= '0;
    else                                  dcnt <= dcnt + DLY_W'(1);
  end

  p_overlap_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    bothHigh |-> (dcnt < dlyCycles));

  p_idle_counter_r6: assert property (@(posedge clk) disable iff (!rstN)
    !bothHigh |=> (dcnt == '0));

endmodule

// File: rtl/pfd_divcore.sv
module pfd_divcore
  import pfd_pkg::*;
#(
  parameter int REF_W = 14,
  parameter int FB_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refStrobe,
  input  logic             fbStrobe,
  input  logic [REF_W-1:0] refRatio,
  input  logic [FB_W-1:0]  fbRatio,
  input  logic [1:0]       abpSel,
  input  logic             powerDown,
  output logic             up,
  output logic             down,
  output logic             refPulse,
  output logic             fbPulse,
  output logic             abpShortWarn
);

  pfd_ctrl_t ctrl;
  logic      upQ;
  logic      dnQ;

  pfd_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .powerDown (powerDown),
    .abpSel    (abpSel),
    .upQ       (upQ),
    .dnQ       (dnQ),
    .ctrl      (ctrl),
    .shortWarn (abpShortWarn)
  );

  pfd_datapath #(.REF_W(REF_W), .FB_W(FB_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .refStrobe (refStrobe),
    .fbStrobe  (fbStrobe),
    .refRatio  (refRatio),
    .fbRatio   (fbRatio),
    .upQ       (upQ),
    .dnQ       (dnQ),
    .refPulse  (refPulse),
    .fbPulse   (fbPulse)
  );

  assign up   = upQ;
  assign down = dnQ;

  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !refPulse && !fbPulse && !up && !down);

endmodule

// File: tb/pfd_divcore_bench.sv
`timescale 1ns/1ps
module pfd_divcore_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refStrobe = 1'b0;
  logic        fbStrobe = 1'b0;
  logic [13:0] refRatio = 14'd1;
  logic [12:0] fbRatio = 13'd1;
  logic [1:0]  abpSel = 2'b00;
  logic        powerDown = 1'b0;
  logic        up, down, refPulse, fbPulse, abpShortWarn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pfd_divcore u_pfd_divcore (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .fbStrobe(fbStrobe),
    .refRatio(refRatio), .fbRatio(fbRatio), .abpSel(abpSel), .powerDown(powerDown),
    .up(up), .down(down), .refPulse(refPulse), .fbPulse(fbPulse),
    .abpShortWarn(abpShortWarn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic ref_strobe(output bit p);
    @(negedge clk) refStrobe = 1'b1;
    @(negedge clk) refStrobe = 1'b0;
    p = refPulse;
  endtask

  task automatic fb_strobe(output bit p);
    @(negedge clk) fbStrobe = 1'b1;
    @(negedge clk) fbStrobe = 1'b0;
    p = fbPulse;
  endtask

  task automatic both_strobe();
    @(negedge clk) begin refStrobe = 1'b1; fbStrobe = 1'b1; end
    @(negedge clk) begin refStrobe = 1'b0; fbStrobe = 1'b0; end
  endtask

  // R9: state right after reset
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(!up && !down, "R9 detector idle", {up, down}, 0);
    chk(!refPulse && !fbPulse, "R9 pulses idle", {refPulse, fbPulse}, 0);
  endtask

  // R1/R2/R3: pulse on every ratio-th strobe only
  task automatic t_divider(input bit isFb, input int ratio, input int periods, input string req);
    int eff = (ratio == 0) ? 1 : ratio;
    int bad = 0;
    int seen = 0;
    if (isFb) fbRatio = 13'(ratio); else refRatio = 14'(ratio);
    do_reset();
    for (int i = 1; i <= eff * periods; i++) begin
      bit p;
      if (isFb) fb_strobe(p); else ref_strobe(p);
      if (p != ((i % eff) == 0)) bad++;
      if (p) seen++;
    end
    chk(bad == 0, req, bad, 0);
    chk(seen == periods, req, seen, periods);
  endtask

  // R4: ratio changed mid-count applies after terminal count
  task automatic t_ratio_change();
    bit p;
    int hits = 0;
    refRatio = 14'd4;
    do_reset();
    ref_strobe(p); if (p) hits++;
    ref_strobe(p); if (p) hits++;
    refRatio = 14'd2;
    ref_strobe(p); if (p) hits++;
    chk(hits == 0, "R4 no early pulse", hits, 0);
    ref_strobe(p);
    chk(p, "R4 old ratio completes", p, 1);
    ref_strobe(p);
    chk(!p, "R4 new ratio first strobe", p, 0);
    ref_strobe(p);
    chk(p, "R4 new ratio terminal", p, 1);
  endtask

  // R5/R6: lead, overlap window, common clear
  task automatic t_overlap(input logic [1:0] code, input int lead, input int expD);
    bit p;
    int n = 0;
    refRatio = 14'd1;
    fbRatio  = 13'd1;
    abpSel   = code;
    do_reset();
    if (lead == 2) begin
      both_strobe();
    end else begin
      if (lead == 0) ref_strobe(p); else fb_strobe(p);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (lead == 0) chk(up && !down, "R5 up leads alone", {up, down}, 2);
        else           chk(!up && down, "R5 down leads alone", {up, down}, 1);
      end
      if (lead == 0) fb_strobe(p); else ref_strobe(p);
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (up && down) n++;
    end
    chk(n == expD, "R6 overlap length", n, expD);
    chk(!up && !down, "R6 both cleared", {up, down}, 0);
  endtask

  // R7: warning decode
  task automatic t_warn();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk) abpSel = 2'(c);
      #1 chk(abpShortWarn == (c == 1), "R7 warn decode", abpShortWarn, c == 1);
    end
    @(negedge clk) begin powerDown = 1'b1; abpSel = 2'b01; end
    #1 chk(abpShortWarn, "R7 warn in power-down", abpShortWarn, 1);
    @(negedge clk) powerDown = 1'b0;
  endtask

  // R8: power-down holds everything and restarts counting
  task automatic t_powerdown();
    bit p;
    int hits = 0;
    refRatio = 14'd3;
    do_reset();
    for (int i = 0; i < 3; i++) ref_strobe(p);
    @(negedge clk);
    chk(up, "R8 up set before power-down", up, 1);
    powerDown = 1'b1;
    @(negedge clk);
    chk(!up && !down, "R8 detector cleared", {up, down}, 0);
    for (int i = 0; i < 5; i++) begin
      ref_strobe(p);
      if (p || up) hits++;
    end
    chk(hits == 0, "R8 strobes ignored", hits, 0);
    powerDown = 1'b0;
    ref_strobe(p); if (p) hits++;
    ref_strobe(p); if (p) hits++;
    chk(hits == 0, "R8 count restarts", hits, 0);
    ref_strobe(p);
    chk(p, "R8 full ratio after release", p, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_divider(1'b0, 5, 3, "R1 reference divide by 5");
    t_divider(1'b0, 1, 4, "R1 reference divide by 1");
    t_divider(1'b0, 16383, 1, "R1 reference maximum ratio");
    t_divider(1'b1, 3, 3, "R2 feedback divide by 3");
    t_divider(1'b1, 8191, 1, "R2 feedback maximum ratio");
    t_divider(1'b0, 0, 3, "R3 reference zero ratio");
    t_divider(1'b1, 0, 3, "R3 feedback zero ratio");
    t_ratio_change();
    t_overlap(2'b01, 0, 2);
    t_overlap(2'b00, 1, 4);
    t_overlap(2'b10, 0, 6);
    t_overlap(2'b11, 2, 8);
    t_warn();
    t_powerdown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule